// File: doc/BRIEF.md
# FIFO Read Gearbox, 96-bit to 32-bit

This block turns a first-word-fall-through pixel FIFO that is read 96 bits at a time into a stream of 32-bit words for a packet controller. Each FIFO word holds four 24-bit RGB pixels packed into 96 bits. The block presents that word to the consumer as three consecutive 32-bit words. A phase counter steers a plain multiplexer over the head word of the FIFO, so no data register sits between the FIFO and the consumer. Output data therefore follows the FIFO output in the same cycle. Because the FIFO shows its head word without a read pulse, the first 32 bits are on the output as soon as the FIFO is non-empty.

The consumer side is a valid/ready stream. `out_valid` is high whenever the FIFO holds a word. A word is taken in a cycle where both `out_valid` and `out_ready` are high. The consumer may hold `out_ready` low for any number of cycles: the phase then holds and the same slice stays on `out_data`. `out_ready` may be raised while `out_valid` is low. That cycle takes nothing and is reported on `rd_underflow`.

The FIFO is popped with `fifo_rd_en` during the third accepted transfer of each word. `clr` is a synchronous clear that goes with a FIFO clear. Everything runs on one clock.

Top module: `fifo_rd_gearbox`

## Requirements
- R1: After reset, with no transfer yet made, `out_data` equals bits [31:0] of `fifo_data` and `fifo_rd_en` is low.
- R2: Slices are given out lowest first: bits [31:0], then [63:32], then [95:64] of the same FIFO word.
- R3: `fifo_rd_en` is high in exactly the cycle of the transfer that takes bits [95:64]. It is high once per three accepted transfers, and never in any other cycle.
- R4: `out_valid` equals the inverse of `fifo_empty`. While valid, `out_data` is the selected slice of `fifo_data` in the same cycle, with no register in the path.
- R5: A cycle with `out_ready` high and `fifo_empty` high raises `rd_underflow` in that cycle. It does not advance the slice selection and does not raise `fifo_rd_en`.
- R6: While `out_ready` is low, the slice selection holds, `fifo_rd_en` stays low and `rd_underflow` stays low.
- R7: `clr` high suppresses `fifo_rd_en` in that cycle and returns the selection to bits [31:0] from the next cycle.
- R8: After a pop, the next FIFO word is given out starting from bits [31:0], so back-to-back transfers make a gap-free sequence of 32-bit words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by FIFO read side and consumer |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of the slice selection |
| fifo_data | input | 96 | Head word of the fall-through FIFO |
| fifo_empty | input | 1 | FIFO empty flag |
| fifo_rd_en | output | 1 | FIFO pop strobe |
| out_data | output | 32 | Current 32-bit slice |
| out_valid | output | 1 | Slice on `out_data` is valid |
| out_ready | input | 1 | Consumer takes the slice when valid |
| rd_underflow | output | 1 | Consumer asked for data while the FIFO was empty |

## Verification
The assertions assume that the FIFO truly falls through. They also assume that `fifo_data` and `fifo_empty` change only at a clock edge that follows a pop, a write or a clear, and never between edges. The bench meets this with a FIFO model that updates only on the rising edge. Every input, including a forced empty flag and `clr`, is driven half a period away from that edge. The assertions place no limit on `out_ready`. The stimulus therefore raises it while the FIFO is empty and holds it low in each phase, so that the hold and underflow properties are exercised.

// File: rtl/gb_pkg.sv
package gb_pkg;
  localparam int unsigned GB_SLICE_W = 32;
  localparam int unsigned GB_SLICES  = 3;

  function automatic int unsigned gb_sel_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/gb_phase_ctr.sv
module gb_phase_ctr #(
  parameter int unsigned SLICES = gb_pkg::GB_SLICES,
  localparam int unsigned SEL_W = gb_pkg::gb_sel_w(SLICES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  output logic [SEL_W-1:0] sel,
  output logic             at_last
);
  localparam logic [SEL_W-1:0] LAST = SEL_W'(SLICES - 1);

  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sel_q <= '0;
    else if (clr)
      sel_q <= '0;
    else if (step)
      sel_q <= (sel_q == LAST) ? '0 : sel_q + 1'b1;
  end

  assign sel     = sel_q;
  assign at_last = (sel_q == LAST);

  AST_SEL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q <= LAST);                                               // R2
  AST_SEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clr) |=> $stable(sel_q));                          // R6
endmodule

// File: rtl/gb_slice_mux.sv
module gb_slice_mux #(
  parameter int unsigned SLICE_W = gb_pkg::GB_SLICE_W,
  parameter int unsigned SLICES  = gb_pkg::GB_SLICES,
  localparam int unsigned SEL_W  = gb_pkg::gb_sel_w(SLICES),
  localparam int unsigned WORD_W = SLICE_W * SLICES
) (
  input  logic [WORD_W-1:0]  word,
  input  logic [SEL_W-1:0]   sel,
  output logic [SLICE_W-1:0] slice
);
  logic [SLICE_W-1:0] lanes [SLICES];
  logic [SLICE_W-1:0] gated [SLICES];

  for (genvar k = 0; k < SLICES; k++) begin : g_lane
    assign lanes[k] = word[k*SLICE_W +: SLICE_W];
    assign gated[k] = (sel == SEL_W'(k)) ? lanes[k] : '0;
  end

  always_comb begin
    slice = '0;
    for (int k = 0; k < SLICES; k++)
      slice = slice | gated[k];
  end
endmodule

// File: rtl/gb_pop_ctl.sv
module gb_pop_ctl (
  input  logic empty,
  input  logic ready,
  input  logic clr,
  input  logic at_last,
  output logic valid,
  output logic step,
  output logic pop,
  output logic underflow
);
  assign valid     = !empty;
  assign step      = valid && ready && !clr;
  assign pop       = step && at_last;
  assign underflow = ready && empty;
endmodule

// File: rtl/fifo_rd_gearbox.sv
module fifo_rd_gearbox #(
  parameter int unsigned SLICE_W = gb_pkg::GB_SLICE_W,
  parameter int unsigned SLICES  = gb_pkg::GB_SLICES,
  localparam int unsigned SEL_W  = gb_pkg::gb_sel_w(SLICES),
  localparam int unsigned WORD_W = SLICE_W * SLICES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic [WORD_W-1:0]  fifo_data,
  input  logic               fifo_empty,
  output logic               fifo_rd_en,
  output logic [SLICE_W-1:0] out_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic               rd_underflow
);
  logic [SEL_W-1:0] sel;
  logic             at_last;
  logic             step;

  gb_pop_ctl u_ctl (
    .empty     (fifo_empty),
    .ready     (out_ready),
    .clr       (clr),
    .at_last   (at_last),
    .valid     (out_valid),
    .step      (step),
    .pop       (fifo_rd_en),
    .underflow (rd_underflow)
  );

  gb_phase_ctr #(.SLICES(SLICES)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .step    (step),
    .sel     (sel),
    .at_last (at_last)
  );

  gb_slice_mux #(.SLICE_W(SLICE_W), .SLICES(SLICES)) u_mux (
    .word  (fifo_data),
    .sel   (sel),
    .slice (out_data)
  );

  AST_POP_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd_en |=> (sel == '0));                                  // R3
  AST_POP_NEEDS_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd_en |-> (out_ready && !fifo_empty));                   // R3
  AST_UNDERFLOW_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_underflow |-> (!fifo_rd_en && !out_valid));                // R5
  AST_UNDERFLOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_underflow && !clr) |=> $stable(sel));                     // R5
  AST_CLEAR_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (sel == '0));                                         // R7
  AST_CLEAR_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> !fifo_rd_en);                                         // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ready |-> (!fifo_rd_en && !rd_underflow));               // R6
endmodule

// File: tb/tb_fifo_rd_gearbox.sv
module tb_fifo_rd_gearbox;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic [95:0] fifo_data;
  logic        fifo_empty;
  logic        fifo_rd_en;
  logic [31:0] out_data;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic        rd_underflow;

  logic        force_empty = 1'b0;
  int          hidx = 0;
  localparam int NWORDS = 48;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  function automatic logic [31:0] lane(input int w, input int k);
    return 32'h5A00_0000 + 32'(w * 16 + k);
  endfunction
  function automatic logic [95:0] word(input int w);
    return {lane(w, 2), lane(w, 1), lane(w, 0)};
  endfunction

  assign fifo_data  = word(hidx);
  assign fifo_empty = force_empty || (hidx >= NWORDS);

  always @(posedge clk)
    if (rst_n && fifo_rd_en && !fifo_empty) hidx <= hidx + 1;

  fifo_rd_gearbox dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .fifo_data(fifo_data),
    .fifo_empty(fifo_empty), .fifo_rd_en(fifo_rd_en), .out_data(out_data),
    .out_valid(out_valid), .out_ready(out_ready), .rd_underflow(rd_underflow)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // {ready, force_empty, exp_phase[1:0], exp_pop, exp_underflow}
  localparam logic [5:0] TBL [12] = '{
    6'b1_0_00_0_0, 6'b1_0_01_0_0, 6'b1_0_10_1_0, 6'b0_0_00_0_0,
    6'b1_1_00_0_1, 6'b1_0_00_0_0, 6'b0_0_01_0_0, 6'b1_1_01_0_1,
    6'b1_0_01_0_0, 6'b0_1_10_0_0, 6'b1_0_10_1_0, 6'b1_0_00_0_0
  };

  initial begin
    int ehead;
    int pops;
    ehead = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    chk("R1 data", out_data, lane(0, 0));
    chk("R1 rd_en", 32'(fifo_rd_en), 32'd0);
    chk("R4 valid", 32'(out_valid), 32'd1);

    // vector walk: R2 R3 R4 R5 R6 R8
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      out_ready   = TBL[i][5];
      force_empty = TBL[i][4];
      #2;
      chk("R4 valid", 32'(out_valid), 32'(!TBL[i][4]));
      if (!TBL[i][4]) chk("R2 slice", out_data, lane(ehead, int'(TBL[i][3:2])));
      chk("R3 rd_en", 32'(fifo_rd_en), 32'(TBL[i][1]));
      chk("R5 underflow", 32'(rd_underflow), 32'(TBL[i][0]));
      if (TBL[i][1]) ehead++;
    end

    // R8: head advanced after pops
    @(negedge clk); out_ready = 1'b0; force_empty = 1'b0; #2;
    chk("R8 head", out_data, lane(ehead, 1));

    // R7: clear at phase 2 with ready high
    @(negedge clk); out_ready = 1'b1; #2;               // phase 1 -> 2
    @(negedge clk); clr = 1'b1; #2;
    chk("R7 slice before clear", out_data, lane(ehead, 2));
    chk("R7 no pop", 32'(fifo_rd_en), 32'd0);
    @(negedge clk); clr = 1'b0; out_ready = 1'b0; #2;
    chk("R7 restart", out_data, lane(ehead, 0));

    // R3 R8: continuous stream of 30 transfers
    pops = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); out_ready = 1'b1; #2;
      chk("R8 stream", out_data, lane(ehead + i / 3, i % 3));
      chk("R3 stream pop", 32'(fifo_rd_en), 32'((i % 3) == 2));
      if (fifo_rd_en) pops++;
    end
    chk("R3 pop count", 32'(pops), 32'd10);
    ehead += 10;

    // R6: ready low in mid word holds slice
    @(negedge clk); #2;                                  // phase 0 -> 1
    @(negedge clk); out_ready = 1'b0; #2;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #2;
      chk("R6 hold", out_data, lane(ehead, 1));
      chk("R6 no pop", 32'(fifo_rd_en), 32'd0);
    end

    // R5: empty with ready high at phase 1, no advance
    @(negedge clk); force_empty = 1'b1; out_ready = 1'b1; #2;
    chk("R5 flag", 32'(rd_underflow), 32'd1);
    chk("R5 no pop", 32'(fifo_rd_en), 32'd0);
    @(negedge clk); force_empty = 1'b0; out_ready = 1'b0; #2;
    chk("R5 no advance", out_data, lane(ehead, 1));

    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end
endmodule